// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a sixteen-line general-purpose I/O controller. Each line is set on its own to drive a pin or to observe one. Software reaches the configuration and the data through a small register bus that takes half-word (16-bit) accesses. Any access of another width is refused with an error response and has no effect.

Lines in output mode drive a stored value on their pin. Lines in input mode are sampled on every clock. A transition in the selected direction on an unmasked input line sets a sticky status bit for that line. One interrupt request is raised while any status bit is set, and software clears status bits by writing ones to them. When the sampled inputs are read back, they are gated by a separate pin-gate register.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every line is an input (`gpioOe` all zero), `gpioOut` is zero, `irq` is low, the mask register reads 0xFFFF, the edge, output and status registers read 0x0000, and the pin-gate register reads 0xFFFF.
- R2: A request with `busSize` = 2'b01 (half-word) receives `busAck` high for one cycle, in the cycle after the request. Read data is valid on `busRdata` while `busAck` is high. The word addresses are: 0x0 output value, 0x2 direction, 0x4 edge select, 0x6 interrupt mask, 0x8 interrupt status, 0xA pin gate, 0xC sampled input (read only).
- R3: A direction bit of 1 makes its line an input, and 0 makes it an output. `gpioOe` is high exactly for output lines. `gpioOut` carries the stored output bit on output lines and 0 on input lines, and it follows changes of either register.
- R4: When a line's edge-select bit is 1, a low-to-high transition of its input sets that line's status bit. A high-to-low transition does not.
- R5: When a line's edge-select bit is 0, a high-to-low transition of its input sets that line's status bit. A low-to-high transition does not.
- R6: A transition on a line that is in output mode, or whose mask bit is 1, leaves the status register unchanged.
- R7: `irq` is high exactly when at least one status bit is set. Status bits stay set until they are cleared by software.
- R8: Writing to the status register clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R9: A read of the sampled-input register returns the registered pin samples ANDed with the pin-gate register.
- R10: A request with `busSize` of 2'b00 (byte), 2'b10 (word) or 2'b11 receives `busErr` instead of `busAck`, and it changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReq | input | 1 | Access request, one cycle per access |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 4 | Byte address of the register |
| busSize | input | 2 | Access width code (01 = half-word) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid with busAck |
| busAck | output | 1 | Access completed |
| busErr | output | 1 | Access refused because of its width |
| gpioIn | input | 16 | Pin levels seen by the block |
| gpioOut | output | 16 | Values driven on output lines |
| gpioOe | output | 16 | Drive enable per line |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an edge that arrives while every qualifying condition except one is met. Examples are an unmasked line that has been switched to output mode, a masked input line, and a line whose edge select points the other way. In the stimulus, the direction, mask and edge-select registers are first programmed so that neighbouring lines differ in exactly one of these conditions. The pins are then toggled in both directions and the status register is read back, so that a wrong qualifier shows up as one extra or one missing status bit. Refused-width writes are aimed at the status and direction registers while bits are set, which shows that the refusal really has no effect.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // width codes on busSize
  localparam logic [1:0] SIZE_HALF = 2'b01;

  // register word addresses
  localparam logic [3:0] ADDR_OUT  = 4'h0;
  localparam logic [3:0] ADDR_DIR  = 4'h2;
  localparam logic [3:0] ADDR_EDGE = 4'h4;
  localparam logic [3:0] ADDR_MASK = 4'h6;
  localparam logic [3:0] ADDR_STAT = 4'h8;
  localparam logic [3:0] ADDR_GATE = 4'hA;
  localparam logic [3:0] ADDR_DIN  = 4'hC;

  typedef enum logic [2:0] {
    SEL_OUT, SEL_DIR, SEL_EDGE, SEL_MASK, SEL_STAT, SEL_GATE, SEL_DIN, SEL_NONE
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e sel;
  } strobe_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output strobe_t           stb,
  output logic              busAck,
  output logic              busErr
);

  logic    sizeOk;
  regSel_e selDec;

  assign sizeOk = (busSize == SIZE_HALF);

  always_comb begin
    case (4'(busAddr))
      ADDR_OUT:  selDec = SEL_OUT;
      ADDR_DIR:  selDec = SEL_DIR;
      ADDR_EDGE: selDec = SEL_EDGE;
      ADDR_MASK: selDec = SEL_MASK;
      ADDR_STAT: selDec = SEL_STAT;
      ADDR_GATE: selDec = SEL_GATE;
      ADDR_DIN:  selDec = SEL_DIN;
      default:   selDec = SEL_NONE;
    endcase
  end

  always_comb begin
    stb.wrEn = busReq && busWr && sizeOk;
    stb.rdEn = busReq && !busWr && sizeOk;
    stb.sel  = selDec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAck <= 1'b0;
      busErr <= 1'b0;
    end else begin
      busAck <= busReq && sizeOk;
      busErr <= busReq && !sizeOk;
    end
  end

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] gpioIn,
  output logic [LINES-1:0] rdata,
  output logic [LINES-1:0] gpioOut,
  output logic [LINES-1:0] gpioOe,
  output logic             irq
);

  localparam logic [LINES-1:0] ALL_ONES = {LINES{1'b1}};

  logic [LINES-1:0] outVal, dirMode, edgeSel, irqMask, irqStat, pinGate;
  logic [LINES-1:0] inSamp, inLast, hit, clrBits;
  logic [LINES-1:0] rdMux;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVal  <= '0;
      dirMode <= ALL_ONES;
      edgeSel <= '0;
      irqMask <= ALL_ONES;
      pinGate <= ALL_ONES;
    end else if (stb.wrEn) begin
      case (stb.sel)
        SEL_OUT:  outVal  <= wdata;
        SEL_DIR:  dirMode <= wdata;
        SEL_EDGE: edgeSel <= wdata;
        SEL_MASK: irqMask <= wdata;
        SEL_GATE: pinGate <= wdata;
        default: ;
      endcase
    end
  end

  // pin sampling: current and previous sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSamp <= '0;
      inLast <= '0;
    end else begin
      inSamp <= gpioIn;
      inLast <= inSamp;
    end
  end

  // per-line edge qualification
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic rise, fall;
    assign rise   = inSamp[i] & ~inLast[i];
    assign fall   = ~inSamp[i] & inLast[i];
    assign hit[i] = (edgeSel[i] ? rise : fall) & dirMode[i] & ~irqMask[i];
  end

  assign clrBits = (stb.wrEn && stb.sel == SEL_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqStat <= '0;
    else       irqStat <= (irqStat & ~clrBits) | hit;
  end

  always_comb begin
    case (stb.sel)
      SEL_OUT:  rdMux = outVal;
      SEL_DIR:  rdMux = dirMode;
      SEL_EDGE: rdMux = edgeSel;
      SEL_MASK: rdMux = irqMask;
      SEL_STAT: rdMux = irqStat;
      SEL_GATE: rdMux = pinGate;
      SEL_DIN:  rdMux = inSamp & pinGate;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdata <= '0;
    else if (stb.rdEn) rdata <= rdMux;
    else               rdata <= '0;
  end

  assign gpioOe  = ~dirMode;
  assign gpioOut = outVal & ~dirMode;
  assign irq     = |irqStat;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [LINES-1:0]  busWdata,
  output logic [LINES-1:0]  busRdata,
  output logic              busAck,
  output logic              busErr,
  input  logic [LINES-1:0]  gpioIn,
  output logic [LINES-1:0]  gpioOut,
  output logic [LINES-1:0]  gpioOe,
  output logic              irq
);

  strobe_t stb;

  gpio_edge_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr),
    .busAddr(busAddr), .busSize(busSize), .stb(stb),
    .busAck(busAck), .busErr(busErr)
  );

  gpio_edge_datapath #(.LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .gpioIn(gpioIn),
    .rdata(busRdata), .gpioOut(gpioOut), .gpioOe(gpioOe), .irq(irq)
  );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int LINES = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busReq,
  input logic             busWr,
  input logic [1:0]       busSize,
  input logic             busAck,
  input logic             busErr,
  input logic [LINES-1:0] gpioOut,
  input logic [LINES-1:0] gpioOe,
  input logic             irq
);

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busAck && busErr)); // R2

  AST_HALF_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busSize == 2'b01 |=> busAck); // R2

  AST_BAD_WIDTH_ERR: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busSize != 2'b01 |=> busErr && !busAck); // R10

  AST_BAD_WIDTH_PINS: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busSize != 2'b01 |=> $stable(gpioOut) && $stable(gpioOe)); // R10

  AST_DRIVE_ONLY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (gpioOut & ~gpioOe) == '0); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irq && !(busReq && busWr && busSize == 2'b01) |=> irq); // R7

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busSize(busSize),
  .busAck(busAck), .busErr(busErr), .gpioOut(gpioOut), .gpioOe(gpioOe),
  .irq(irq)
);

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [1:0]  busSize = 2'b01;
  logic [15:0] busWdata = '0, gpioIn = 16'h00F0;
  logic [15:0] busRdata, gpioOut, gpioOe;
  logic        busAck, busErr, irq;

  int checks = 0, fails = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_edge_irq uut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .busErr(busErr), .gpioIn(gpioIn), .gpioOut(gpioOut),
    .gpioOe(gpioOe), .irq(irq)
  );

  // {wr, addr, size, wdata, expErr, chkRd, expRd}
  localparam int NV = 18;
  localparam logic [40:0] TBL [NV] = '{
    {1'b0, 4'h2, 2'b01, 16'h0000, 1'b0, 1'b1, 16'hFFFF}, // R1 direction
    {1'b0, 4'h6, 2'b01, 16'h0000, 1'b0, 1'b1, 16'hFFFF}, // R1 mask
    {1'b0, 4'hA, 2'b01, 16'h0000, 1'b0, 1'b1, 16'hFFFF}, // R1 gate
    {1'b0, 4'h8, 2'b01, 16'h0000, 1'b0, 1'b1, 16'h0000}, // R1 status
    {1'b0, 4'h4, 2'b01, 16'h0000, 1'b0, 1'b1, 16'h0000}, // R1 edge
    {1'b0, 4'h0, 2'b01, 16'h0000, 1'b0, 1'b1, 16'h0000}, // R1 output
    {1'b0, 4'hC, 2'b01, 16'h0000, 1'b0, 1'b1, 16'h00F0}, // R9 full gate
    {1'b1, 4'hA, 2'b01, 16'h0030, 1'b0, 1'b0, 16'h0000}, // R2 write gate
    {1'b0, 4'hC, 2'b01, 16'h0000, 1'b0, 1'b1, 16'h0030}, // R9 partial gate
    {1'b1, 4'hA, 2'b01, 16'hFFFF, 1'b0, 1'b0, 16'h0000}, // R2
    {1'b1, 4'h0, 2'b01, 16'hA5A5, 1'b0, 1'b0, 16'h0000}, // R2
    {1'b0, 4'h0, 2'b01, 16'h0000, 1'b0, 1'b1, 16'hA5A5}, // R2 readback
    {1'b1, 4'h2, 2'b01, 16'hFF00, 1'b0, 1'b0, 16'h0000}, // R3 low byte out
    {1'b1, 4'h2, 2'b00, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R10 byte write
    {1'b0, 4'h2, 2'b01, 16'h0000, 1'b0, 1'b1, 16'hFF00}, // R10 unchanged
    {1'b0, 4'h0, 2'b10, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R10 word read
    {1'b1, 4'h0, 2'b11, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R10 bad code
    {1'b0, 4'h0, 2'b01, 16'h0000, 1'b0, 1'b1, 16'hA5A5}  // R10 unchanged
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] addr, input logic [1:0] size,
                        input logic [15:0] data, output logic ack, output logic err,
                        output logic [15:0] rd);
    @(negedge clk);
    busReq = 1'b1; busWr = wr; busAddr = addr; busSize = size; busWdata = data;
    @(negedge clk);
    ack = busAck; err = busErr; rd = busRdata;
    busReq = 1'b0; busWr = 1'b0; busSize = 2'b01;
  endtask

  task automatic wr16(input logic [3:0] addr, input logic [15:0] data);
    logic a, e; logic [15:0] r;
    access(1'b1, addr, 2'b01, data, a, e, r);
  endtask

  task automatic rd16(input logic [3:0] addr, output logic [15:0] r);
    logic a, e;
    access(1'b0, addr, 2'b01, 16'h0, a, e, r);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic a, e;
    logic [15:0] r;
    repeat (3) @(negedge clk);
    check("R1 irq low", irq, 0);
    check("R1 oe zero", gpioOe, 16'h0000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 out zero", gpioOut, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      access(TBL[i][40], TBL[i][39:36], TBL[i][35:34], TBL[i][33:18], a, e, r);
      check($sformatf("R2/R10 row %0d err", i), e, TBL[i][17]);
      check($sformatf("R2/R10 row %0d ack", i), a, !TBL[i][17]);
      if (TBL[i][16]) check($sformatf("table row %0d read", i), r, TBL[i][15:0]);
    end

    // R3 direction and driven values
    check("R3 oe", gpioOe, 16'h00FF);
    check("R3 out", gpioOut, 16'h00A5);

    // program edges: line 8 rising, others falling; unmask lines 0..9
    wr16(4'h4, 16'h0100);
    wr16(4'h6, 16'hFC00);
    settle();
    check("R7 no irq yet", irq, 0);

    gpioIn = 16'h01F0; settle();           // R4 rise on line 8
    check("R7 irq set", irq, 1);
    rd16(4'h8, r); check("R4 rising sets", r, 16'h0100);

    gpioIn = 16'h03F0; settle();           // R5 rise on falling-select line 9
    rd16(4'h8, r); check("R5 rise ignored", r, 16'h0100);
    gpioIn = 16'h01F0; settle();           // R5 fall on line 9
    rd16(4'h8, r); check("R5 falling sets", r, 16'h0300);
    gpioIn = 16'h00F0; settle();           // R4 fall on rising-select line 8
    rd16(4'h8, r); check("R4 fall ignored", r, 16'h0300);

    // R6 output lines 0..3 and masked line 12 toggled both ways
    gpioIn = 16'h10FF; settle();
    gpioIn = 16'h00F0; settle();
    rd16(4'h8, r); check("R6 out/masked ignored", r, 16'h0300);

    // R10 refused write to status
    access(1'b1, 4'h8, 2'b00, 16'hFFFF, a, e, r);
    check("R10 stat write err", e, 1);
    rd16(4'h8, r); check("R10 status kept", r, 16'h0300);
    check("R7 irq held", irq, 1);

    wr16(4'h8, 16'h0100);
    rd16(4'h8, r); check("R8 partial clear", r, 16'h0200);
    check("R7 irq still", irq, 1);
    wr16(4'h8, 16'h0200);
    rd16(4'h8, r); check("R8 full clear", r, 16'h0000);
    check("R7 irq cleared", irq, 0);

    // R3 turning lines 4..7 into inputs drops their drive
    wr16(4'h2, 16'hFFF0);
    check("R3 oe after dir", gpioOe, 16'h000F);
    check("R3 out after dir", gpioOut, 16'h0005);
    wr16(4'h0, 16'h000A);
    check("R3 out follows value", gpioOut, 16'h000A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule